// File: doc/BRIEF.md
# Bipolar Receive Line Decoder with Zero-Run Alarm

This block sits on the receive side of one T1 or E1 channel, after clock recovery and slicing. Each clock of the recovered line clock brings one bipolar symbol on two rails: a pulse on the positive rail, a pulse on the negative rail, or neither. The block undoes the zero-substitution line code of the selected standard. For T1 it removes the eight-bit B8ZS code, and for E1 the four-bit HDB3 code. It then delivers NRZ data, either merged onto one output or kept as two rails.

To give substitution detection a full view of each candidate pattern, the symbols pass through a short delay line. The output lags the line by a fixed number of clocks that depends on the standard. Beside the data path, a counter tracks the run of consecutive zero symbols on the line. A digital loss-of-signal alarm rises when that run reaches the threshold for the selected standard. The alarm drops again as soon as a pulse arrives.

Top module: `line_rx_decoder`

## Requirements
- R1: With `std_e1`=0 and `code_en`=1, an eight-symbol run 0,0,0,V,B,0,V',B' is output as eight zeros. In this run, V and B are single-rail pulses of opposite polarity, V' has the polarity of B, and B' has the polarity of V. A positive-rail pulse counts as positive polarity and a negative-rail pulse as negative.
- R2: With `std_e1`=1 and `code_en`=1, a run 0,0,0,V is output as four zeros when V has the same polarity as the most recent pulse received before it. When V has the opposite polarity, the run is passed unchanged.
- R3: With `std_e1`=1 and `code_en`=1, a run B,0,0,V in which B and V have the same polarity is output as four zeros.
- R4: With `code_en`=0, no substitution is removed, and every pulse reaches the output as received.
- R5: A symbol sampled at clock edge k is seen on the outputs after edge k+8 when `std_e1`=0, and after edge k+4 when `std_e1`=1.
- R6: With `dual_rail`=0, `rx_data` is high for a pulse on either rail, and `rx_neg_data` stays low.
- R7: With `dual_rail`=1, `rx_data` carries the positive rail and `rx_neg_data` carries the negative rail.
- R8: A symbol with both rails high is treated as a pulse. `rx_cv` is high in the same output cycle as that symbol.
- R9: With `std_e1`=0, `los` rises at the edge that samples the 100th consecutive zero symbol, and not earlier.
- R10: With `std_e1`=1, `los` rises at the edge that samples the 255th consecutive zero symbol, and not earlier.
- R11: `los` falls at the edge that samples the first pulse after it was raised. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one symbol per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pos | input | 1 | Positive-rail pulse of the current symbol |
| rx_neg | input | 1 | Negative-rail pulse of the current symbol |
| std_e1 | input | 1 | 0 selects T1 (B8ZS, 100-zero alarm); 1 selects E1 (HDB3, 255-zero alarm) |
| code_en | input | 1 | 1 enables removal of substitution codes |
| dual_rail | input | 1 | 1 gives two-rail output; 0 gives one merged data output |
| rx_data | output | 1 | Decoded NRZ data, or positive rail in dual-rail mode |
| rx_neg_data | output | 1 | Decoded negative rail in dual-rail mode, low otherwise |
| rx_cv | output | 1 | Both rails were high for the symbol now on the outputs |
| los | output | 1 | Digital loss-of-signal alarm |

## Verification
The hardest case to reach from the ports is a bipolar violation that must not be removed. One example is an E1 run 0,0,0,V whose V alternates correctly against the previous pulse. Another is a code pattern sent while `code_en` is low. Both depend on the hidden last-pulse polarity and on the alignment of the delay line. The stimulus therefore tracks the polarity of the last pulse it drove across test phases. It sends each pattern twice: once so that it must be erased, and once with the polarity flipped or the enable off so that it must survive. The scoreboard compares every output cycle at the exact latency for the standard.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
    typedef struct packed {
        logic p;
        logic n;
    } sym_t;

    localparam int B8_WIN = 8;
    localparam int HD_WIN = 4;
endpackage

// File: rtl/lrx_subst_det.sv
module lrx_subst_det
    import lrx_pkg::*;
#(
    parameter int WIN  = B8_WIN,
    parameter int HWIN = HD_WIN
) (
    input  sym_t [WIN-1:0] win,
    input  logic           last_pol,
    input  logic           e1,
    input  logic           en,
    output logic [WIN-1:0] clr
);
    localparam logic [WIN-1:0] HMASK = WIN'((1 << HWIN) - 1);

    function automatic logic mk(input sym_t s);
        return s.p | s.n;
    endfunction

    logic b8_hit, hz_hit, hb_hit;

    always_comb begin
        b8_hit = !e1 && en &&
                 !mk(win[7]) && !mk(win[6]) && !mk(win[5]) &&
                 mk(win[4]) && mk(win[3]) && !mk(win[2]) && mk(win[1]) && mk(win[0]) &&
                 (win[4].p != win[3].p) && (win[3].p == win[1].p) && (win[4].p == win[0].p);
        hz_hit = e1 && en &&
                 !mk(win[3]) && !mk(win[2]) && !mk(win[1]) && mk(win[0]) &&
                 (win[0].p == last_pol);
        hb_hit = e1 && en &&
                 mk(win[3]) && !mk(win[2]) && !mk(win[1]) && mk(win[0]) &&
                 (win[3].p == win[0].p);
        if (b8_hit)
            clr = '1;
        else if (hz_hit || hb_hit)
            clr = HMASK;
        else
            clr = '0;
    end
endmodule

// File: rtl/lrx_los.sv
module lrx_los #(
    parameter int ZW     = 8,
    parameter int T1_LOS = 100,
    parameter int E1_LOS = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    input  logic e1,
    output logic los
);
    typedef struct packed {
        logic [ZW-1:0] cnt;
        logic          alarm;
    } ls_t;

    ls_t           los_d, los_q;
    logic [ZW-1:0] thr;

    always_comb begin
        thr   = e1 ? ZW'(E1_LOS) : ZW'(T1_LOS);
        los_d = los_q;
        if (mark) begin
            los_d = '0;
        end else begin
            if (los_q.cnt != '1)
                los_d.cnt = los_q.cnt + 1'b1;
            if (los_d.cnt >= thr)
                los_d.alarm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            los_q <= '0;
        else
            los_q <= los_d;
    end

    assign los = los_q.alarm;
endmodule

// File: rtl/line_rx_decoder.sv
module line_rx_decoder
    import lrx_pkg::*;
#(
    parameter int ZW     = 8,
    parameter int T1_LOS = 100,
    parameter int E1_LOS = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic std_e1,
    input  logic code_en,
    input  logic dual_rail,
    output logic rx_data,
    output logic rx_neg_data,
    output logic rx_cv,
    output logic los
);
    typedef struct packed {
        sym_t [B8_WIN-1:0] sr;
        sym_t              out;
        logic              lpol;
    } st_t;

    st_t                st_d, st_q;
    sym_t               in_s;
    sym_t [B8_WIN-1:0]  win;
    logic [B8_WIN-1:0]  clr;

    assign in_s = {rx_pos, rx_neg};

    always_comb begin
        win[0] = in_s;
        for (int k = 1; k < B8_WIN; k++)
            win[k] = st_q.sr[k-1];
    end

    lrx_subst_det #(.WIN(B8_WIN), .HWIN(HD_WIN)) u_det (
        .win      (win),
        .last_pol (st_q.lpol),
        .e1       (std_e1),
        .en       (code_en),
        .clr      (clr)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < B8_WIN; k++)
            st_d.sr[k] = clr[k] ? '0 : win[k];
        st_d.out = std_e1 ? st_q.sr[HD_WIN-1] : st_q.sr[B8_WIN-1];
        if (rx_pos || rx_neg)
            st_d.lpol = rx_pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    lrx_los #(.ZW(ZW), .T1_LOS(T1_LOS), .E1_LOS(E1_LOS)) u_los (
        .clk   (clk),
        .rst_n (rst_n),
        .mark  (rx_pos | rx_neg),
        .e1    (std_e1),
        .los   (los)
    );

    assign rx_data     = dual_rail ? st_q.out.p : (st_q.out.p | st_q.out.n);
    assign rx_neg_data = dual_rail & st_q.out.n;
    assign rx_cv       = st_q.out.p & st_q.out.n;
endmodule

// File: rtl/lrx_decoder_chk.sv
module lrx_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_pos,
    input logic rx_neg,
    input logic std_e1,
    input logic code_en,
    input logic rx_cv,
    input logic los
);
    logic [3:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= '0;
        else if (cyc != 4'hF)
            cyc <= cyc + 1'b1;
    end

    AST_LOS_DROP_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pos || rx_neg) |=> !los); // R11

    AST_LOS_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> !$past(rx_pos || rx_neg)); // R9

    AST_LOS_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (los && !rx_pos && !rx_neg) |=> los); // R10

    AST_E1_CV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'd10 && $past(std_e1) && !$past(code_en, 2) && !$past(code_en, 3) &&
         !$past(code_en, 4) && !$past(code_en, 5))
        |-> (rx_cv == $past(rx_pos && rx_neg, 5))); // R5

    AST_T1_CV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'd10 && !$past(std_e1) && !$past(code_en, 2) && !$past(code_en, 3) &&
         !$past(code_en, 4) && !$past(code_en, 5) && !$past(code_en, 6) &&
         !$past(code_en, 7) && !$past(code_en, 8) && !$past(code_en, 9))
        |-> (rx_cv == $past(rx_pos && rx_neg, 9))); // R8
endmodule

bind line_rx_decoder lrx_decoder_chk u_chk (.*);

// File: tb/sim_line_rx_decoder.sv
module sim_line_rx_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pos = 1'b0, rx_neg = 1'b0;
    logic std_e1 = 1'b0, code_en = 1'b0, dual_rail = 1'b0;
    logic rx_data, rx_neg_data, rx_cv, los;

    int checks = 0;
    int fails = 0;
    int ecnt = 0;
    bit done = 0;

    int         due_q[$];
    logic [1:0] exp_q[$];
    string      tag_q[$];

    line_rx_decoder u0 (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .std_e1(std_e1), .code_en(code_en), .dual_rail(dual_rail),
        .rx_data(rx_data), .rx_neg_data(rx_neg_data), .rx_cv(rx_cv), .los(los)
    );

    always #10 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // symbol code: 1 = positive rail, -1 = negative rail, 2 = both rails, 0 = none
    task automatic send(input int v, input int ev, input string tag);
        rx_pos = (v == 1) || (v == 2);
        rx_neg = (v == -1) || (v == 2);
        due_q.push_back(ecnt + 1 + (std_e1 ? 4 : 8));
        exp_q.push_back({(ev == 1) || (ev == 2), (ev == -1) || (ev == 2)});
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic play(input int s[$], input int e[$], input string tag);
        foreach (s[i]) send(s[i], e[i], tag);
    endtask

    task automatic drain();
        rx_pos = 1'b0;
        rx_neg = 1'b0;
        while (due_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] == ecnt) begin
            logic [1:0] e;
            string      t;
            logic       ed, en, ec;
            void'(due_q.pop_front());
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            ed = dual_rail ? e[1] : (e[1] | e[0]);
            en = dual_rail & e[0];
            ec = e[1] & e[0];
            chk({rx_data, rx_neg_data, rx_cv} == {ed, en, ec},
                $sformatf("%s at R5 latency {data,neg,cv}", t),
                {rx_data, rx_neg_data, rx_cv}, {ed, en, ec});
        end
    end

    always @(posedge clk) begin
        if (ecnt == 60000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", ecnt, 60000);
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rx_data, rx_neg_data, rx_cv, los} == 4'b0, "R11 reset outputs",
            {rx_data, rx_neg_data, rx_cv, los}, 0);

        // T1, code removal on, single rail
        code_en = 1'b1;
        play('{1, 0, -1, 0,  0, 0, 0, -1, 1, 0, 1, -1,  1, 0, -1,  0, 0, 0, 1, -1, 0, -1, 1,  -1, 1},
             '{1, 0, -1, 0,  0, 0, 0, 0, 0, 0, 0, 0,    1, 0, -1,  0, 0, 0, 0, 0, 0, 0, 0,    -1, 1},
             "R1 B8ZS removal");
        drain();

        // T1, code removal off: patterns pass through
        code_en = 1'b0;
        play('{0, 0, 0, 1, -1, 0, -1, 1, -1},
             '{0, 0, 0, 1, -1, 0, -1, 1, -1}, "R4 no removal");
        drain();

        // E1, HDB3 removal; last pulse sent so far is negative
        std_e1 = 1'b1;
        code_en = 1'b1;
        play('{1, 0, 0, 0, 1,  -1, 0, 0, -1,  1, 0, -1},
             '{1, 0, 0, 0, 0,   0, 0, 0, 0,   1, 0, -1}, "R2 R3 HDB3 removal");
        play('{0, 0, 0, 1, -1}, '{0, 0, 0, 1, -1}, "R2 alternating pulse kept");
        drain();

        // dual rail, both-rail symbols, no removal
        code_en = 1'b0;
        dual_rail = 1'b1;
        play('{1, -1, 2, 0, -1, 1}, '{1, -1, 2, 0, -1, 1}, "R7 R8 dual rail");
        drain();
        dual_rail = 1'b0;
        play('{2, 0, -1, 1, 2}, '{2, 0, -1, 1, 2}, "R6 R8 single rail");
        drain();

        // T1 alarm threshold
        std_e1 = 1'b0;
        send(1, 1, "R9 lead pulse");
        repeat (99) send(0, 0, "R9 zeros");
        chk(los == 1'b0, "R9 los after 99 zeros", los, 0);
        send(0, 0, "R9 zeros");
        chk(los == 1'b1, "R9 los after 100 zeros", los, 1);
        send(0, 0, "R9 zeros");
        chk(los == 1'b1, "R9 los held", los, 1);
        send(-1, -1, "R11 pulse");
        chk(los == 1'b0, "R11 los cleared by pulse", los, 0);
        drain();

        // E1 alarm threshold
        std_e1 = 1'b1;
        send(1, 1, "R10 lead pulse");
        repeat (254) send(0, 0, "R10 zeros");
        chk(los == 1'b0, "R10 los after 254 zeros", los, 0);
        send(0, 0, "R10 zeros");
        chk(los == 1'b1, "R10 los after 255 zeros", los, 1);
        send(2, 2, "R11 both-rail pulse");
        chk(los == 1'b0, "R11 los cleared by both-rail pulse", los, 0);
        drain();

        chk(due_q.size() == 0, "R5 scoreboard empty", due_q.size(), 0);
        done = 1;
        report();
    end
endmodule